// File: doc/BRIEF.md
# UART Transmitter Core

This block turns bytes written by a host into asynchronous serial frames. A one-byte holding register takes each write; a separate shift register sends the frame, so the host may write the next character while the current one is still on the line. All bit timing comes from a single-cycle enable, `tick16`, that pulses sixteen times per bit period. The divisor that produces it lives outside this block.

Framing is set by a group of static configuration inputs: the character length (5 to 8 bits), parity (off, odd, even, or stuck at a constant), and the stop length (1, 1.5 or 2 bits). The block samples these when a frame starts. A break input drives the line low for as long as it is held, and leaves the shifter running underneath. Two flags report progress: `hold_empty` says another byte may be written, and `tx_empty` says the line has gone quiet.

Top module: `uart_tx_core`

## Requirements
- R1: After reset, and whenever the transmitter is idle with break clear, `txd` is 1; after reset `hold_empty` = 1 and `tx_empty` = 1.
- R2: A frame begins with a start bit at 0, followed by the data bits least significant first, then the stop level 1. `cfg_wlen` selects the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Only those low-order bits of the byte are sent. Each start, data and parity bit lasts 16 ticks.
- R3: When `cfg_par_en` = 1 and `cfg_par_stick` = 0, a parity bit follows the data bits. With `cfg_par_even` = 1 it is the XOR of the sent data bits (even parity). With `cfg_par_even` = 0 it is the inverse of that XOR (odd parity). When `cfg_par_en` = 0, no parity bit is sent.
- R4: When `cfg_par_en` = 1 and `cfg_par_stick` = 1, the parity bit is 0 if `cfg_par_even` = 1 and 1 if `cfg_par_even` = 0, whatever the data.
- R5: When `cfg_stop_sel` = 0, the stop level lasts 16 ticks. When `cfg_stop_sel` = 1, it lasts 24 ticks for 5-bit characters and 32 ticks for 6-, 7- or 8-bit characters.
- R6: While `cfg_break` = 1, `txd` is 0. Frame timing and both flags go on unaffected, and the line returns to the frame's level once break clears.
- R7: `hold_empty` falls on the clock after a write. Once that byte has moved to the shifter, `hold_empty` rises on the eighth tick after the tick that started its start bit.
- R8: If the holding register is full when the last stop tick ends, the next start bit begins on that same tick, with no idle gap.
- R9: `tx_empty` is 1 only when the holding register is empty and the last stop bit has finished. It stays 1 until the next write.
- R10: A write while `hold_empty` = 0 replaces the byte waiting in the holding register.
- R11: The character length, parity and stop settings are sampled on the tick that starts a frame. Changing them mid-frame affects only later frames.
- R12: On cycles with no tick and no write, `txd` (with break unchanged), `hold_empty` and `tx_empty` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick16 | input | 1 | Single-cycle enable at 16 times the bit rate |
| wr_valid | input | 1 | Host write strobe for the holding register |
| wr_data | input | DATA_W | Byte to transmit |
| cfg_wlen | input | 2 | Character length code (00 = 5 bits … 11 = 8 bits) |
| cfg_stop_sel | input | 1 | 0 = one stop bit, 1 = longer stop (1.5 or 2 bits) |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_even | input | 1 | 1 = even parity, 0 = odd parity |
| cfg_par_stick | input | 1 | Send parity as a constant |
| cfg_break | input | 1 | Hold the line low |
| txd | output | 1 | Serial output, idles high |
| hold_empty | output | 1 | Holding register can take a byte |
| tx_empty | output | 1 | Holding register and shifter both empty |

## Verification
A wrong bit counter or a stale state register shows on `txd` within one bit period, as a level or an edge at the wrong tick. It can also show as a start bit missing between back-to-back frames. Wrong parity or a wrongly latched frame setting shows on the line at the parity bit or the stop boundary of the affected frame. A hold register that releases at the wrong moment shows on `hold_empty` within a few ticks of the start bit, and as a lost or repeated character in the next frame. For these reasons the bench compares all three outputs with a reference model on every clock.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_START  = 3'd1,
        ST_DATA   = 3'd2,
        ST_PARITY = 3'd3,
        ST_STOP   = 3'd4
    } tx_state_e;

    typedef struct packed {
        logic [1:0] wlen;
        logic       stop_sel;
        logic       par_en;
        logic       par_even;
        logic       par_stick;
    } line_cfg_t;

endpackage

// File: rtl/uart_tx_holdreg.sv
module uart_tx_holdreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              load_i,
    input  logic              free_i,
    output logic              full_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic              full;
        logic              sent;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (wr_i) begin
            hold_d.data = wr_data_i;
            hold_d.full = 1'b1;
            hold_d.sent = 1'b0;
        end else begin
            if (load_i) begin
                hold_d.sent = 1'b1;
            end
            if (free_i && hold_q.sent) begin
                hold_d.full = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign full_o = hold_q.full;
    assign data_o = hold_q.data;

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TPB    = 16,
    parameter int CNT_W  = $clog2(2 * TPB),
    parameter int IDX_W  = $clog2(DATA_W + 1)
) (
    input  logic [DATA_W-1:0] data_i,
    input  line_cfg_t         cfg_i,
    output logic [IDX_W-1:0]  nbits_o,
    output logic              par_en_o,
    output logic              par_bit_o,
    output logic [CNT_W-1:0]  stop_last_o
);

    localparam int MIN_BITS   = DATA_W - 3;
    localparam int STOP_ONE   = TPB - 1;
    localparam int STOP_HALF  = TPB + (TPB / 2) - 1;
    localparam int STOP_TWO   = 2 * TPB - 1;

    logic ones;

    always_comb begin
        nbits_o = IDX_W'(MIN_BITS) + IDX_W'(cfg_i.wlen);
        ones    = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (IDX_W'(i) < nbits_o) begin
                ones = ones ^ data_i[i];
            end
        end

        par_en_o = cfg_i.par_en;
        if (cfg_i.par_stick) begin
            par_bit_o = ~cfg_i.par_even;
        end else if (cfg_i.par_even) begin
            par_bit_o = ones;
        end else begin
            par_bit_o = ~ones;
        end

        if (!cfg_i.stop_sel) begin
            stop_last_o = CNT_W'(STOP_ONE);
        end else if (cfg_i.wlen == 2'b00) begin
            stop_last_o = CNT_W'(STOP_HALF);
        end else begin
            stop_last_o = CNT_W'(STOP_TWO);
        end
    end

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int TPB    = 16,
    parameter int CNT_W  = $clog2(2 * TPB),
    parameter int IDX_W  = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              hold_full_i,
    input  logic [DATA_W-1:0] frame_data_i,
    input  logic [IDX_W-1:0]  nbits_i,
    input  logic              par_en_i,
    input  logic              par_bit_i,
    input  logic [CNT_W-1:0]  stop_last_i,
    output logic              load_o,
    output logic              free_o,
    output logic              busy_o,
    output logic              line_o
);

    localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(TPB - 1);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'((TPB / 2) - 1);

    typedef struct packed {
        tx_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] sh;
        logic [IDX_W-1:0]  idx;
        logic [IDX_W-1:0]  nb;
        logic              pen;
        logic              pbit;
        logic [CNT_W-1:0]  slast;
    } shf_t;

    shf_t shf_d, shf_q;
    logic load, free_hold, bit_end, stop_end;

    always_comb begin
        shf_d     = shf_q;
        load      = 1'b0;
        free_hold = 1'b0;
        bit_end   = (shf_q.cnt == BIT_LAST);
        stop_end  = (shf_q.cnt == shf_q.slast);

        if (tick_i) begin
            case (shf_q.st)
                ST_IDLE: begin
                    load = hold_full_i;
                end
                ST_START: begin
                    free_hold = (shf_q.cnt == HALF_LAST);
                    if (bit_end) begin
                        shf_d.st  = ST_DATA;
                        shf_d.cnt = '0;
                        shf_d.idx = '0;
                    end else begin
                        shf_d.cnt = shf_q.cnt + CNT_W'(1);
                    end
                end
                ST_DATA: begin
                    if (bit_end) begin
                        shf_d.cnt = '0;
                        shf_d.sh  = shf_q.sh >> 1;
                        if (shf_q.idx == shf_q.nb - IDX_W'(1)) begin
                            shf_d.st = shf_q.pen ? ST_PARITY : ST_STOP;
                        end else begin
                            shf_d.idx = shf_q.idx + IDX_W'(1);
                        end
                    end else begin
                        shf_d.cnt = shf_q.cnt + CNT_W'(1);
                    end
                end
                ST_PARITY: begin
                    if (bit_end) begin
                        shf_d.st  = ST_STOP;
                        shf_d.cnt = '0;
                    end else begin
                        shf_d.cnt = shf_q.cnt + CNT_W'(1);
                    end
                end
                ST_STOP: begin
                    if (stop_end) begin
                        if (hold_full_i) begin
                            load = 1'b1;
                        end else begin
                            shf_d.st  = ST_IDLE;
                            shf_d.cnt = '0;
                        end
                    end else begin
                        shf_d.cnt = shf_q.cnt + CNT_W'(1);
                    end
                end
                default: begin
                    shf_d.st  = ST_IDLE;
                    shf_d.cnt = '0;
                end
            endcase
        end

        if (load) begin
            shf_d.st    = ST_START;
            shf_d.cnt   = '0;
            shf_d.idx   = '0;
            shf_d.sh    = frame_data_i;
            shf_d.nb    = nbits_i;
            shf_d.pen   = par_en_i;
            shf_d.pbit  = par_bit_i;
            shf_d.slast = stop_last_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shf_q    <= '0;
            shf_q.st <= ST_IDLE;
        end else begin
            shf_q <= shf_d;
        end
    end

    always_comb begin
        case (shf_q.st)
            ST_START:  line_o = 1'b0;
            ST_DATA:   line_o = shf_q.sh[0];
            ST_PARITY: line_o = shf_q.pbit;
            default:   line_o = 1'b1;
        endcase
    end

    assign load_o = load;
    assign free_o = free_hold;
    assign busy_o = (shf_q.st != ST_IDLE);

endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
    import uart_tx_pkg::*;
#(
    parameter int DATA_W        = 8,
    parameter int TICKS_PER_BIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [1:0]        cfg_wlen,
    input  logic              cfg_stop_sel,
    input  logic              cfg_par_en,
    input  logic              cfg_par_even,
    input  logic              cfg_par_stick,
    input  logic              cfg_break,
    output logic              txd,
    output logic              hold_empty,
    output logic              tx_empty
);

    localparam int CNT_W = $clog2(2 * TICKS_PER_BIT);
    localparam int IDX_W = $clog2(DATA_W + 1);

    line_cfg_t         cfg;
    logic              hold_full;
    logic [DATA_W-1:0] hold_data;
    logic [IDX_W-1:0]  fr_nbits;
    logic              fr_par_en;
    logic              fr_par_bit;
    logic [CNT_W-1:0]  fr_stop_last;
    logic              shf_load;
    logic              shf_free;
    logic              shf_busy;
    logic              shf_line;

    always_comb begin
        cfg.wlen      = cfg_wlen;
        cfg.stop_sel  = cfg_stop_sel;
        cfg.par_en    = cfg_par_en;
        cfg.par_even  = cfg_par_even;
        cfg.par_stick = cfg_par_stick;
    end

    uart_tx_holdreg #(.DATA_W(DATA_W)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_i      (wr_valid),
        .wr_data_i (wr_data),
        .load_i    (shf_load),
        .free_i    (shf_free),
        .full_o    (hold_full),
        .data_o    (hold_data)
    );

    uart_tx_framer #(
        .DATA_W (DATA_W),
        .TPB    (TICKS_PER_BIT),
        .CNT_W  (CNT_W),
        .IDX_W  (IDX_W)
    ) u_framer (
        .data_i      (hold_data),
        .cfg_i       (cfg),
        .nbits_o     (fr_nbits),
        .par_en_o    (fr_par_en),
        .par_bit_o   (fr_par_bit),
        .stop_last_o (fr_stop_last)
    );

    uart_tx_shifter #(
        .DATA_W (DATA_W),
        .TPB    (TICKS_PER_BIT),
        .CNT_W  (CNT_W),
        .IDX_W  (IDX_W)
    ) u_shift (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick_i       (tick16),
        .hold_full_i  (hold_full),
        .frame_data_i (hold_data),
        .nbits_i      (fr_nbits),
        .par_en_i     (fr_par_en),
        .par_bit_i    (fr_par_bit),
        .stop_last_i  (fr_stop_last),
        .load_o       (shf_load),
        .free_o       (shf_free),
        .busy_o       (shf_busy),
        .line_o       (shf_line)
    );

    assign txd        = cfg_break ? 1'b0 : shf_line;
    assign hold_empty = ~hold_full;
    assign tx_empty   = ~hold_full & ~shf_busy;

endmodule

// File: rtl/uart_tx_core_chk.sv
module uart_tx_core_chk (
    input logic clk,
    input logic rst_n,
    input logic tick16,
    input logic wr_valid,
    input logic cfg_break,
    input logic txd,
    input logic hold_empty,
    input logic tx_empty,
    input logic busy
);

    // R1: quiet transmitter keeps the line marking
    assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !cfg_break) |-> txd);

    // R2: the first cycle of a frame shows the start level
    assert_frame_starts_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy) && !cfg_break) |-> !txd);

    // R6: break overrides the line
    assert_break_forces_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_break |-> !txd);

    // R7: a write occupies the holding register on the next clock
    assert_write_fills_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !hold_empty);

    // R7: the holding register only frees on a tick without a write
    assert_release_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_empty) |-> ($past(tick16) && !$past(wr_valid)));

    // R9: an empty transmitter stays empty until written
    assert_empty_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_empty && !wr_valid) |=> tx_empty);

    // R12: no tick and no write leave the flags and shifter state alone
    assert_no_tick_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick16 && !wr_valid) |=> ($stable(busy) && $stable(hold_empty) && $stable(tx_empty)));

endmodule

bind uart_tx_core uart_tx_core_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick16     (tick16),
    .wr_valid   (wr_valid),
    .cfg_break  (cfg_break),
    .txd        (txd),
    .hold_empty (hold_empty),
    .tx_empty   (tx_empty),
    .busy       (shf_busy)
);

// File: tb/tb_uart_tx_core.sv
module tb_uart_tx_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] cfg_wlen = 2'b11;
    logic       cfg_stop_sel = 1'b0;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_even = 1'b0;
    logic       cfg_par_stick = 1'b0;
    logic       cfg_break = 1'b0;
    logic       txd, hold_empty, tx_empty;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req = "R1";
    bit    run_cmp = 1'b0;
    bit    done = 1'b0;

    int  tick_div = 2;
    int  tick_ph = 0;
    bit  tick_en = 1'b0;
    int  tick_total = 0;
    int  cyc = 0;

    // reference model state
    bit       m_q[$];
    bit       m_full = 1'b0;
    bit       m_sent = 1'b0;
    bit [7:0] m_data = 8'h00;
    int       m_pops = 0;

    uart_tx_core dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick16        (tick16),
        .wr_valid      (wr_valid),
        .wr_data       (wr_data),
        .cfg_wlen      (cfg_wlen),
        .cfg_stop_sel  (cfg_stop_sel),
        .cfg_par_en    (cfg_par_en),
        .cfg_par_even  (cfg_par_even),
        .cfg_par_stick (cfg_par_stick),
        .cfg_break     (cfg_break),
        .txd           (txd),
        .hold_empty    (hold_empty),
        .tx_empty      (tx_empty)
    );

    // 100 MHz: 10-unit period
    always #5 clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    always @(negedge clk) begin
        if (!tick_en) begin
            tick16 <= 1'b0;
            tick_ph <= 0;
        end else if (tick_ph >= tick_div - 1) begin
            tick16 <= 1'b1;
            tick_ph <= 0;
        end else begin
            tick16 <= 1'b0;
            tick_ph <= tick_ph + 1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (tick16) tick_total <= tick_total + 1;
        if (cyc > 150000) begin
            n_errors++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 150000);
            finish_run();
        end
    end

    // behavioural reference: a frame is a per-tick queue of line levels
    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete();
            m_full = 1'b0;
            m_sent = 1'b0;
            m_data = 8'h00;
            m_pops = 0;
        end else begin
            bit launch;
            bit rel;
            bit cand;
            int nb;
            bit p;
            int stop_ticks;
            launch = 1'b0;
            rel = 1'b0;
            cand = 1'b0;
            if (tick16) begin
                if (m_q.size() > 0) begin
                    void'(m_q.pop_front());
                    m_pops++;
                    if (m_pops == 8) rel = 1'b1;
                    if (m_q.size() == 0) cand = 1'b1;
                end else begin
                    cand = 1'b1;
                end
                if (cand && m_full) begin
                    nb = 5 + int'(cfg_wlen);
                    p = 1'b0;
                    for (int i = 0; i < nb; i++) p = p ^ m_data[i];
                    if (cfg_par_stick) p = ~cfg_par_even;
                    else if (!cfg_par_even) p = ~p;
                    stop_ticks = !cfg_stop_sel ? 16 : (cfg_wlen == 2'b00 ? 24 : 32);
                    for (int k = 0; k < 16; k++) m_q.push_back(1'b0);
                    for (int i = 0; i < nb; i++)
                        for (int k = 0; k < 16; k++) m_q.push_back(m_data[i]);
                    if (cfg_par_en)
                        for (int k = 0; k < 16; k++) m_q.push_back(p);
                    for (int k = 0; k < stop_ticks; k++) m_q.push_back(1'b1);
                    m_pops = 0;
                    launch = 1'b1;
                end
            end
            if (wr_valid) begin
                m_data = wr_data;
                m_full = 1'b1;
                m_sent = 1'b0;
            end else begin
                if (rel && m_sent) m_full = 1'b0;
                if (launch) m_sent = 1'b1;
            end
        end
    end

    // compare every clock, away from both edges
    always @(posedge clk) begin
        #3;
        if (rst_n && run_cmp) begin
            bit exp_line;
            exp_line = cfg_break ? 1'b0 : (m_q.size() > 0 ? m_q[0] : 1'b1);
            chk(cur_req, "txd", int'(txd), int'(exp_line));
            chk(cur_req, "hold_empty", int'(hold_empty), int'(!m_full));
            chk(cur_req, "tx_empty", int'(tx_empty), int'(!m_full && m_q.size() == 0));
        end
    end

    task automatic write_byte(input logic [7:0] b);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data = b;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_idle();
        for (int g = 0; g < 5000; g++) begin
            @(negedge clk);
            if (tx_empty) break;
        end
    endtask

    task automatic wait_hold_empty();
        for (int g = 0; g < 5000; g++) begin
            @(negedge clk);
            if (hold_empty) break;
        end
    endtask

    task automatic set_cfg(input logic [1:0] wl, input logic st, input logic pe,
                           input logic ev, input logic sk);
        @(negedge clk);
        cfg_wlen = wl;
        cfg_stop_sel = st;
        cfg_par_en = pe;
        cfg_par_even = ev;
        cfg_par_stick = sk;
    endtask

    initial begin
        int t0;
        int t1;
        logic hold_txd;
        logic hold_he;
        logic hold_te;

        repeat (4) @(negedge clk);
        // R1: flags and line during and after reset
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "reset txd", int'(txd), 1);
        chk("R1", "reset hold_empty", int'(hold_empty), 1);
        chk("R1", "reset tx_empty", int'(tx_empty), 1);
        run_cmp = 1'b1;
        tick_en = 1'b1;
        repeat (10) @(negedge clk);

        // R2: each word length, no parity, one stop
        cur_req = "R2";
        for (int w = 0; w < 4; w++) begin
            set_cfg(2'(w), 1'b0, 1'b0, 1'b0, 1'b0);
            write_byte(8'hA5 ^ 8'(w * 8'h37));
            wait_idle();
        end

        // R3: even and odd parity
        cur_req = "R3";
        set_cfg(2'b11, 1'b0, 1'b1, 1'b1, 1'b0);
        write_byte(8'h6B);
        wait_idle();
        set_cfg(2'b11, 1'b0, 1'b1, 1'b0, 1'b0);
        write_byte(8'h6B);
        wait_idle();
        set_cfg(2'b01, 1'b0, 1'b1, 1'b1, 1'b0);
        write_byte(8'hC7);
        wait_idle();

        // R4: stick parity both ways
        cur_req = "R4";
        set_cfg(2'b10, 1'b0, 1'b1, 1'b1, 1'b1);
        write_byte(8'h7F);
        wait_idle();
        set_cfg(2'b10, 1'b0, 1'b1, 1'b0, 1'b1);
        write_byte(8'h00);
        wait_idle();

        // R5: long stop with 5-bit and 7-bit characters
        cur_req = "R5";
        set_cfg(2'b00, 1'b1, 1'b0, 1'b0, 1'b0);
        write_byte(8'h15);
        wait_idle();
        set_cfg(2'b10, 1'b1, 1'b1, 1'b1, 1'b0);
        write_byte(8'h2C);
        wait_idle();

        // R7: hold_empty timing measured at the ports
        cur_req = "R7";
        set_cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        write_byte(8'h81);
        chk("R7", "hold_empty after write", int'(hold_empty), 0);
        for (int g = 0; g < 200; g++) begin
            if (!txd) break;
            @(negedge clk);
        end
        t0 = tick_total;
        wait_hold_empty();
        t1 = tick_total;
        chk("R7", "ticks from start to hold_empty", t1 - t0, 8);
        // R9: still busy shifting though holding register is free
        chk("R9", "tx_empty while shifting", int'(tx_empty), 0);
        wait_idle();
        chk("R9", "tx_empty after last stop", int'(tx_empty), 1);

        // R8: back-to-back frames with a tick every clock
        cur_req = "R8";
        tick_div = 1;
        write_byte(8'h3C);
        wait_hold_empty();
        write_byte(8'hF0);
        wait_hold_empty();
        write_byte(8'h0F);
        wait_idle();
        tick_div = 2;

        // R10: overwrite of a waiting byte
        cur_req = "R10";
        write_byte(8'h11);
        wait_hold_empty();
        write_byte(8'h22);
        write_byte(8'hDB);
        chk("R10", "hold_empty while waiting", int'(hold_empty), 0);
        wait_idle();

        // R11: settings changed mid-frame
        cur_req = "R11";
        set_cfg(2'b11, 1'b0, 1'b0, 1'b0, 1'b0);
        write_byte(8'h96);
        repeat (60) @(negedge clk);
        set_cfg(2'b00, 1'b1, 1'b1, 1'b1, 1'b0);
        write_byte(8'h0B);
        wait_idle();

        // R6: break during a frame and while idle
        cur_req = "R6";
        set_cfg(2'b11, 1'b0, 1'b1, 1'b0, 1'b0);
        write_byte(8'hFF);
        repeat (80) @(negedge clk);
        cfg_break = 1'b1;
        @(negedge clk);
        chk("R6", "txd under break mid-frame", int'(txd), 0);
        repeat (40) @(negedge clk);
        cfg_break = 1'b0;
        wait_idle();
        cfg_break = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6", "txd under break idle", int'(txd), 0);
        chk("R6", "tx_empty under break idle", int'(tx_empty), 1);
        cfg_break = 1'b0;
        @(negedge clk);
        chk("R6", "txd after break release", int'(txd), 1);

        // R12: ticks paused mid-frame
        cur_req = "R12";
        write_byte(8'h5A);
        repeat (70) @(negedge clk);
        tick_en = 1'b0;
        repeat (3) @(negedge clk);
        hold_txd = txd;
        hold_he = hold_empty;
        hold_te = tx_empty;
        repeat (40) @(negedge clk);
        chk("R12", "txd frozen", int'(txd), int'(hold_txd));
        chk("R12", "hold_empty frozen", int'(hold_empty), int'(hold_he));
        chk("R12", "tx_empty frozen", int'(tx_empty), int'(hold_te));
        tick_en = 1'b1;
        wait_idle();

        repeat (20) @(negedge clk);
        finish_run();
    end

endmodule